// File: doc/BRIEF.md
# Peripheral Reset Control Register Bank

This block holds the reset lines of many on-chip peripherals in a few registers on a simple 32-bit register bus. There are two 32-bit reset control words. Each has two write addresses. Writing ones at the word's base address sets those bits, which holds the matching peripherals in reset. Writing ones at base plus 4 clears those bits, which releases them. Bits written as zero are left as they are, so software never needs a read-modify-write to change a single reset.

A third register is a plain read/write word. Bit 0 drives one extra reset line that is active low: a stored 0 holds that peripheral in reset and a stored 1 releases it. This register has no set or clear alias, so it is rewritten as a whole word.

All reset outputs come straight from register flops. Reads are combinational from the address. Writes take effect on the rising clock edge on which write enable is sampled high.

Top module: `rst_ctrl_bank`

## Requirements
- R1: After rst_ni is asserted, control word 0 (offset 0x200) reads 0xFFFFFFFF. Control word 1 (offset 0x220) reads 0xFFFFF7FF. The plain register (offset 0x908) reads 0, so rst_aux_no is low.
- R2: A write to offset 0x200 or 0x220 sets every bit of that word where wdata_i is 1. Bits where wdata_i is 0 keep their value.
- R3: A write to offset 0x204 or 0x224 clears every bit of that word where wdata_i is 1. Bits where wdata_i is 0 keep their value.
- R4: A read at a word's base offset returns the word. Bit i of word 0 drives rst_o[i] and bit i of word 1 drives rst_o[32+i]. A 1 means the reset is asserted.
- R5: A read at a clear alias (0x204, 0x224) returns the same value as the word's base offset.
- R6: A write to offset 0x908 stores the full 32-bit wdata_i, which then reads back at 0x908. rst_aux_no follows its bit 0, and low means the reset is asserted.
- R7: Bit 11 of word 1 is reserved. It reads 0, rst_o[43] stays 0, and neither set nor clear writes change it.
- R8: Reads at any unmapped address return 0. Writes to unmapped addresses, and bus cycles with wr_en_i low, change no register.
- R9: A write becomes visible on rst_o, rst_aux_no and rdata_o on the clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| rst_o | output | 64 | Peripheral resets, active high, word 1 in the upper half |
| rst_aux_no | output | 1 | Extra peripheral reset, active low |

## Verification
A flop in a control word holding the wrong value shows up at once on its rst_o bit. The same word then reads back wrong at both its base address and its clear alias. No extra cycle is needed beyond the write that caused the error. A decode fault that mixes up set, clear or unmapped addresses appears on the next read after that single write. The reserved bit and the active-low auxiliary line are checked straight after reset and after writes that try to disturb them. A slip of one cycle in write timing is caught by sampling outputs just before and just after the writing edge.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 32;
  localparam int NUM_WORDS   = 2;
  localparam int BANK_BASE   = 'h200;
  localparam int WORD_STRIDE = 'h20;
  localparam int CLR_OFS     = 4;
  localparam int PLAIN_ADDR  = 'h908;

  function automatic logic [ADDR_W-1:0] word_base(input int idx);
    return ADDR_W'(BANK_BASE + idx * WORD_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] word_clr(input int idx);
    return ADDR_W'(BANK_BASE + idx * WORD_STRIDE + CLR_OFS);
  endfunction
endpackage

// File: rtl/rst_ctrl_decode.sv
module rst_ctrl_decode
  import rst_ctrl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = NUM_WORDS
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  output logic [NW-1:0] set_en_o,
  output logic [NW-1:0] clr_en_o,
  output logic [NW-1:0] rd_word_o,
  output logic          plain_wr_o,
  output logic          plain_rd_o,
  output logic          rd_hit_o
);
  logic [NW-1:0] hit_set, hit_clr;

  for (genvar g = 0; g < NW; g++) begin : g_dec
    assign hit_set[g]   = (addr_i == AW'(word_base(g)));
    assign hit_clr[g]   = (addr_i == AW'(word_clr(g)));
    assign set_en_o[g]  = wr_en_i & hit_set[g];
    assign clr_en_o[g]  = wr_en_i & hit_clr[g];
    assign rd_word_o[g] = hit_set[g] | hit_clr[g];
  end

  assign plain_rd_o = (addr_i == AW'(PLAIN_ADDR));
  assign plain_wr_o = wr_en_i & plain_rd_o;
  assign rd_hit_o   = plain_rd_o | (|rd_word_o);
endmodule

// File: rtl/rst_ctrl_word.sv
module rst_ctrl_word #(
  parameter int               W         = 32,
  parameter logic [W-1:0]     RSVD_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LIVE    = ~RSVD_MASK;
  localparam logic [W-1:0] RST_VAL = LIVE;

  logic [W-1:0] set_m, clr_m, q_d, q_q;

  assign set_m = set_en_i ? wdata_i : '0;
  assign clr_m = clr_en_i ? wdata_i : '0;
  // clear applied last so it wins over a simultaneous set
  assign q_d   = ((q_q | set_m) & ~clr_m) & LIVE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && !clr_en_i) |=> ((q_q & $past(wdata_i & LIVE)) == $past(wdata_i & LIVE)));

  a_r3_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((q_q & $past(wdata_i)) == '0));

  a_r2_r3_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i || clr_en_i) |=> (((q_q ^ $past(q_q)) & ~$past(wdata_i)) == '0));

  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i) |=> $stable(q_q));

  a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q & RSVD_MASK) == '0);
endmodule

// File: rtl/rst_ctrl_plain.sv
module rst_ctrl_plain #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (wr_en_i) q_q <= wdata_i;
  end

  assign q_o = q_q;

  a_r6_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (q_q == $past(wdata_i)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_q));
endmodule

// File: rtl/rst_ctrl_bank.sv
module rst_ctrl_bank
  import rst_ctrl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NW = NUM_WORDS,
  parameter logic [NW*DW-1:0] RSVD_MASK = {32'h0000_0800, 32'h0000_0000}
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_en_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NW*DW-1:0] rst_o,
  output logic           rst_aux_no
);
  logic [NW-1:0]         set_en, clr_en, rd_word;
  logic                  plain_wr, plain_rd, rd_hit;
  logic [NW-1:0][DW-1:0] word_q;
  logic [DW-1:0]         plain_q;

  rst_ctrl_decode #(.AW(AW), .NW(NW)) i_decode (
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .set_en_o   (set_en),
    .clr_en_o   (clr_en),
    .rd_word_o  (rd_word),
    .plain_wr_o (plain_wr),
    .plain_rd_o (plain_rd),
    .rd_hit_o   (rd_hit)
  );

  for (genvar g = 0; g < NW; g++) begin : g_word
    rst_ctrl_word #(
      .W         (DW),
      .RSVD_MASK (RSVD_MASK[g*DW +: DW])
    ) i_word (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_en_i (set_en[g]),
      .clr_en_i (clr_en[g]),
      .wdata_i  (wdata_i),
      .q_o      (word_q[g])
    );
    assign rst_o[g*DW +: DW] = word_q[g];

    a_r5_alias_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == AW'(word_clr(g))) |-> (rdata_o == word_q[g]));
  end

  rst_ctrl_plain #(.W(DW)) i_plain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (plain_wr),
    .wdata_i (wdata_i),
    .q_o     (plain_q)
  );

  assign rst_aux_no = plain_q[0];

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NW; i++)
      if (rd_word[i]) rdata_o = word_q[i];
    if (plain_rd) rdata_o = plain_q;
  end

  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> (rdata_o == '0));

  a_r8_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_en, clr_en, plain_wr}));
endmodule

// File: tb/test_rst_ctrl_bank.sv
module test_rst_ctrl_bank;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] exp;
  } vec_t;

  // running state after reset: w0=FFFFFFFF w1=FFFFF7FF plain=0
  localparam vec_t VECS [13] = '{
    '{1'b1, 12'h204, 32'hFFFF_FFFF, 12'h200, 32'h0000_0000}, // R3
    '{1'b1, 12'h224, 32'hFFFF_FFFF, 12'h220, 32'h0000_0000}, // R3
    '{1'b1, 12'h200, 32'h0000_00A5, 12'h200, 32'h0000_00A5}, // R2
    '{1'b1, 12'h200, 32'h0000_0F00, 12'h204, 32'h0000_0FA5}, // R2 R5
    '{1'b1, 12'h204, 32'h0000_0081, 12'h200, 32'h0000_0F24}, // R3
    '{1'b1, 12'h220, 32'h0000_0800, 12'h220, 32'h0000_0000}, // R7
    '{1'b1, 12'h220, 32'h8000_0FFF, 12'h224, 32'h8000_07FF}, // R2 R7 R5
    '{1'b1, 12'h224, 32'h0000_00F0, 12'h220, 32'h8000_070F}, // R3
    '{1'b1, 12'h908, 32'h1234_5679, 12'h908, 32'h1234_5679}, // R6
    '{1'b1, 12'h300, 32'hFFFF_FFFF, 12'h200, 32'h0000_0F24}, // R8
    '{1'b1, 12'h908, 32'h0000_0000, 12'h908, 32'h0000_0000}, // R6
    '{1'b1, 12'h90C, 32'h0000_AAAA, 12'h90C, 32'h0000_0000}, // R8
    '{1'b0, 12'h204, 32'hFFFF_FFFF, 12'h200, 32'h0000_0F24}  // R8
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] rst_o;
  logic        rst_aux_no;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rst_ctrl_bank i_rst_ctrl_bank (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rdata_o, .rst_o, .rst_aux_no
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic we, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wr_en_i = we; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    bus_read(12'h200, rd); check("R1 word0", 64'(rd), 64'hFFFF_FFFF);
    bus_read(12'h220, rd); check("R1 word1", 64'(rd), 64'hFFFF_F7FF);
    bus_read(12'h908, rd); check("R1 plain", 64'(rd), 64'h0);
    check("R1 R4 rst_o", rst_o, 64'hFFFF_F7FF_FFFF_FFFF);
    check("R1 R6 aux low", 64'(rst_aux_no), 64'h0);
    check("R7 rst_o[43]", 64'(rst_o[43]), 64'h0);

    for (int i = 0; i < 13; i++) begin
      bus_write(VECS[i].we, VECS[i].waddr, VECS[i].wdata);
      bus_read(VECS[i].raddr, rd);
      check($sformatf("vector %0d (R2 R3 R5 R6 R7 R8)", i), 64'(rd), 64'(VECS[i].exp));
    end

    // R4 output mapping
    check("R4 rst_o map", rst_o, 64'h8000_070F_0000_0F24);
    check("R7 rst_o[43] after writes", 64'(rst_o[43]), 64'h0);
    check("R6 aux after zero write", 64'(rst_aux_no), 64'h0);

    // R9 timing: aux releases only at the edge sampling the write
    @(negedge clk_i);
    addr_i = 12'h908; wr_en_i = 1'b1; wdata_i = 32'h0000_0001;
    @(posedge clk_i); #1;
    check("R9 R6 aux after edge", 64'(rst_aux_no), 64'h1);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    addr_i = 12'h200; wr_en_i = 1'b1; wdata_i = 32'h8000_0000;
    #1 check("R9 rst_o[31] before edge", 64'(rst_o[31]), 64'h0);
    @(posedge clk_i); #1;
    check("R9 R2 rst_o[31] after edge", 64'(rst_o[31]), 64'h1);
    @(negedge clk_i);
    wr_en_i = 1'b0;

    // R7 clear on reserved bit is harmless too
    bus_write(1'b1, 12'h224, 32'h0000_0800);
    bus_read(12'h220, rd); check("R7 clear reserved", 64'(rd), 64'h8000_070F);

    // R1 reset mid-run restores defaults
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    check("R1 rst_o after re-reset", rst_o, 64'hFFFF_F7FF_FFFF_FFFF);
    check("R1 aux after re-reset", 64'(rst_aux_no), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule